// File: doc/BRIEF.md
# Loadable Binary Counter with Shared Data Bus

This block is a small synchronous up-counter whose parallel-load data and a tri-stated copy of its count share one group of bus pins. A direction control made from the load and output-disable inputs decides whether those pins listen or drive. The shared pins are split into a separate input vector, output vector and output-enable, so an I/O cell or bus fabric outside the block does the actual three-state drive.

A clear input with the highest priority zeroes the count at once, without waiting for a clock edge. Apart from that, every change happens on the rising clock edge. A load takes the bus value, an enabled cycle adds one, and a disabled cycle holds the count. A dedicated count output always shows the register. An active-low terminal flag can be wired straight into the active-low enable of a following stage, so that stages chain into a wider counter.

Top module: `bus_counter`

## Requirements
- R1: While `clr` is high the count is 0 at once, without a clock edge, whatever the load, enable, output-disable and bus inputs are.
- R2: With `clr` low and `load_n` low, a rising clock edge writes `io_in` into the count, whether `cnt_en_n` is high or low.
- R3: With `load_n` high and `cnt_en_n` low, each rising clock edge adds one to the count.
- R4: With `load_n` high and `cnt_en_n` high, the count keeps its value across clock edges.
- R5: Adding one to 4'b1111 gives 4'b0000.
- R6: `io_oe` is 1 exactly when `load_n` is 1 and `out_dis` is 0. In the other three combinations the bus pins are released (`io_oe` = 0). `io_out` always carries the count.
- R7: `q` always shows the count, whatever `out_dis` and `load_n` are.
- R8: `max_cnt_n` is 0 exactly when the count is 4'b1111 and `cnt_en_n` is 0. Otherwise it is 1.
- R9: When one stage counts freely and a second stage takes its `cnt_en_n` from the first stage's `max_cnt_n`, the pair counts through 0 to 255 as one 8-bit counter and then wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| load_n | input | 1 | Parallel load from the bus, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| out_dis | input | 1 | Disables the drive of the shared bus pins, active high |
| io_in | input | 4 | Value received from the shared bus pins |
| io_out | output | 4 | Value for the shared bus pins (the count) |
| io_oe | output | 1 | Drive enable for the shared bus pins |
| q | output | 4 | Always-driven count |
| max_cnt_n | output | 1 | Terminal count flag for cascading, active low |

## Verification
Every one of the 16 bus values is loaded, once with the enable asserted and once with it released. Each loaded value is then followed by one enabled edge and one disabled edge. This separates load priority from counting, shows that increment and hold are exact at every value, and covers the wrap at 15. The four load/output-disable pairs are applied at a nonzero count, which shows that only the bus enable depends on them and the dedicated outputs do not. A clear pulse raised between edges, with load held low, shows that clear acts at once and wins over load. A two-stage chain run for 256 edges shows that the flag marks each wrap clock of the low stage and nothing else.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Next count for an enabled cycle; wraps naturally at the register width.
  function automatic logic [3:0] bump4(input logic [3:0] cur);
    return cur + 4'd1;
  endfunction

  // True when every bit of the count is set.
  function automatic logic all_ones4(input logic [3:0] cur);
    return &cur;
  endfunction
endpackage

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_n,
  input  logic         cnt_en_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] cnt
);
  import cnt_pkg::*;

  logic do_load;
  logic do_inc;
  assign do_load = ~load_n;
  assign do_inc  = load_n & ~cnt_en_n;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)          cnt <= '0;
    else if (do_load) cnt <= d_in;
    else if (do_inc)  cnt <= W'(bump4(4'(cnt)));
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) (clr && $past(clr)) |-> (cnt == '0)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (clr) !load_n |=> (cnt == $past(d_in))); // R2
  AST_INC_ONE:    assert property (@(posedge clk) disable iff (clr) (load_n && !cnt_en_n) |=> (cnt == W'($past(cnt) + 1'b1))); // R3
  AST_HOLD_KEEP:  assert property (@(posedge clk) disable iff (clr) (load_n && cnt_en_n) |=> $stable(cnt)); // R4
endmodule

// File: rtl/cnt_pins.sv
module cnt_pins #(
  parameter int W = 4
) (
  input  logic [W-1:0] cnt,
  input  logic         load_n,
  input  logic         out_dis,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic [W-1:0] q_out
);
  assign bus_oe  = load_n & ~out_dis;
  assign bus_out = cnt;
  assign q_out   = cnt;

  always_comb begin
    AST_BUS_QUIET_ON_LOAD: assert (!(bus_oe && !load_n)); // R6
  end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] cnt,
  input  logic         cnt_en_n,
  output logic         tc_n
);
  import cnt_pkg::*;

  logic at_top;
  assign at_top = all_ones4(4'(cnt));
  assign tc_n   = ~(at_top & ~cnt_en_n);
endmodule

// File: rtl/bus_counter.sv
module bus_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_n,
  input  logic         cnt_en_n,
  input  logic         out_dis,
  input  logic [W-1:0] io_in,
  output logic [W-1:0] io_out,
  output logic         io_oe,
  output logic [W-1:0] q,
  output logic         max_cnt_n
);
  logic [W-1:0] cnt_w;
  logic         tc_w;

  cnt_reg #(.W(W)) u_reg (
    .clk(clk), .clr(clr), .load_n(load_n), .cnt_en_n(cnt_en_n),
    .d_in(io_in), .cnt(cnt_w)
  );

  cnt_pins #(.W(W)) u_pins (
    .cnt(cnt_w), .load_n(load_n), .out_dis(out_dis),
    .bus_out(io_out), .bus_oe(io_oe), .q_out(q)
  );

  cnt_carry #(.W(W)) u_carry (
    .cnt(cnt_w), .cnt_en_n(cnt_en_n), .tc_n(tc_w)
  );

  assign max_cnt_n = tc_w;

  AST_FLAG_THEN_WRAP: assert property (@(posedge clk) disable iff (clr) (!tc_w && load_n) |=> (cnt_w == '0)); // R5
  AST_FLAG_NEEDS_EN:  assert property (@(posedge clk) disable iff (clr) cnt_en_n |-> tc_w); // R8
endmodule

// File: tb/test_bus_counter.sv
`timescale 1ns/1ps
module test_bus_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr, load_n, cnt_en_n, out_dis;
  logic [3:0] io_in, io_out, q;
  logic       io_oe, max_cnt_n;

  bus_counter i_bus_counter (
    .clk(clk), .clr(clr), .load_n(load_n), .cnt_en_n(cnt_en_n), .out_dis(out_dis),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .q(q), .max_cnt_n(max_cnt_n)
  );

  // Cascade pair
  logic       c_clr, c_load_n;
  logic [3:0] lo_q, hi_q, lo_bo, hi_bo;
  logic       lo_oe, hi_oe, lo_tc, hi_tc;

  bus_counter i_lo (
    .clk(clk), .clr(c_clr), .load_n(c_load_n), .cnt_en_n(1'b0), .out_dis(1'b0),
    .io_in(4'd0), .io_out(lo_bo), .io_oe(lo_oe), .q(lo_q), .max_cnt_n(lo_tc)
  );
  bus_counter i_hi (
    .clk(clk), .clr(c_clr), .load_n(c_load_n), .cnt_en_n(lo_tc), .out_dis(1'b0),
    .io_in(4'd0), .io_out(hi_bo), .io_oe(hi_oe), .q(hi_q), .max_cnt_n(hi_tc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clr = 1'b1; load_n = 1'b1; cnt_en_n = 1'b1; out_dis = 1'b0; io_in = 4'd9;
    c_clr = 1'b1; c_load_n = 1'b1;
    edge_step(); edge_step();
    chk("R1 reset count", q, 0);
    chk("R8 reset flag", max_cnt_n, 1);
    clr = 1'b0; c_clr = 1'b0;
    edge_step();

    // Load every value with both enable levels; then one increment and one hold.
    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 2; e++) begin
        load_n = 1'b0; cnt_en_n = e[0]; io_in = 4'(v);
        edge_step();
        chk("R2 load", q, v);
        chk("R6 bus released during load", io_oe, 0);
        load_n = 1'b1; cnt_en_n = 1'b1; io_in = 4'(~v);
        #0.5;
        chk("R8 flag with enable off", max_cnt_n, 1);
        edge_step();
        chk("R4 hold", q, v);
        cnt_en_n = 1'b0;
        #0.5;
        chk("R8 flag with enable on", max_cnt_n, (v == 15) ? 0 : 1);
        edge_step();
        chk(v == 15 ? "R5 wrap" : "R3 increment", q, (v + 1) % 16);
        chk("R6 bus value", io_out, (v + 1) % 16);
      end
    end

    // Pin direction, all four load/out_dis combinations at count 6.
    load_n = 1'b0; io_in = 4'd6; cnt_en_n = 1'b1;
    edge_step();
    for (int c = 0; c < 4; c++) begin
      load_n = c[1]; out_dis = c[0]; io_in = 4'd6;
      #0.5;
      chk("R6 oe combination", io_oe, (c[1] && !c[0]) ? 1 : 0);
      chk("R7 count output", q, 6);
      chk("R6 bus value", io_out, 6);
    end
    out_dis = 1'b0;

    // Clear between edges wins over load.
    load_n = 1'b0; io_in = 4'd13;
    edge_step();
    chk("R2 load before clear", q, 13);
    #1 clr = 1'b1;
    #0.5;
    chk("R1 async clear", q, 0);
    edge_step();
    chk("R1 clear over load", q, 0);
    clr = 1'b0; load_n = 1'b1; cnt_en_n = 1'b1;
    edge_step();

    // Cascade: load zero into both, then 256 enabled edges.
    c_load_n = 1'b0;
    edge_step();
    c_load_n = 1'b1;
    for (int k = 1; k <= 256; k++) begin
      chk("R8 low-stage flag", lo_tc, (((k - 1) % 16) == 15) ? 0 : 1);
      edge_step();
      chk("R9 cascade value", {hi_q, lo_q}, k % 256);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule